// File: doc/BRIEF.md
# Glitch-free master clock selector with prescaler

This block builds a chip's master clock from one of three sources: a 32 kHz slow clock, a main oscillator clock and a PLL clock. A source change never puts a shortened pulse on the output. The selector first shuts the outgoing source's gate and waits until that gate is confirmed closed. It then leaves a fixed quiet gap counted in slow clock cycles. Last, it opens the incoming source's gate after a fixed count of that source's own cycles. Both gates switch on a falling edge of their own clock.

A power-of-two prescaler follows the selector and divides by 1 to 64. The result drives the internal master clock and an output pad that can be tri-stated. The control side runs on the slow clock and takes one write strobe that carries these fields:

- a source code
- a divide code
- a pad-disable bit
- an interrupt mask
- a flag-clear bit

Software watches a sticky "now on slow clock" flag, and its maskable interrupt, to learn when the oscillator or the PLL may be stopped.

Top module: `mck_switch`

## Requirements
- R1: Source codes are 00 slow, 01 oscillator, 10 PLL. After reset the slow clock is selected. After a switch completes, `src_now` shows the new code and, at divide-by-1, the master clock period equals that source's period.
- R2: At most one source gate is open at any time. The old gate closes before the new one opens. No high or low phase of the master clock is shorter than half the period of the fastest source involved.
- R3: `busy` is high at the first falling slow clock edge after an accepted write that changes the source. It stays high through the close handshake, a gap of GAP_CYCLES slow cycles and ON_CYCLES cycles of the new clock. It then falls within 40 slow cycles of the write.
- R4: A write that arrives while `busy` is high is ignored entirely: source, divide code, mask and pad bit all keep their values.
- R5: Source code 11, or a code equal to the current source, starts no switch, and `busy` stays low.
- R6: Divide code n (0 to 6) makes the master clock period 2^n source periods, with equal high and low phases for n ≥ 1.
- R7: The divide code resets to 0 (divide-by-1). Code 7 leaves the current ratio unchanged.
- R8: A new ratio takes effect only at a division period boundary, so no phase is cut short.
- R9: `slow_flag` sets when a switch to the slow clock completes. It stays set until a write with `cfg_flag_clr` = 1 and clears at the next slow edge.
- R10: `irq` is high exactly when `slow_flag` and the stored mask bit are both 1. The mask resets to 0.
- R11: With the pad-disable bit at 0 (reset value), `mck_pad` carries the master clock. With the bit at 1, `mck_pad` is high impedance.

Control fields are sampled on the rising edge of `clk_slow` while `cfg_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | 32 kHz slow clock; also clocks the control logic |
| clk_osc | input | 1 | Main oscillator clock |
| clk_pll | input | 1 | PLL clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control fields |
| cfg_src | input | 2 | Source code: 00 slow, 01 oscillator, 10 PLL, 11 keep |
| cfg_div | input | 3 | Prescaler code n, divide by 2^n; 7 keeps the ratio |
| cfg_pad_off | input | 1 | 1 tri-states the master clock pad |
| cfg_irq_mask | input | 1 | Interrupt enable for the slow-clock flag |
| cfg_flag_clr | input | 1 | Write 1 to clear the slow-clock flag |
| busy | output | 1 | Source switch in progress |
| src_now | output | 2 | Source currently driving the master clock |
| slow_flag | output | 1 | Sticky: switch to slow clock completed |
| irq | output | 1 | Masked slow-clock interrupt |
| mck | output | 1 | Master clock |
| mck_pad | output | 1 | Master clock pad, high impedance when disabled |

## Verification
The selector is driven through directed transitions between all three sources, including moves into and out of the slow clock. Each move is judged by the measured period and high time of the pad, which tells a wrong source or a stuck gate apart from a correct switch. Seeded random pairs of source and divide code then cover the mix of ratios and sources. Throughout, a phase-width monitor watches for runt pulses, which separates a glitch-free handover from one that merely ends on the right clock. The reserved codes, a write during a switch and the flag, mask and pad bits each get directed cases, and each is judged at the ports.

// File: rtl/mck_pkg.sv
package mck_pkg;
   localparam int NSRC  = 3;
   localparam int SRC_W = 2;
   localparam int DIV_W = 3;

   typedef enum logic [SRC_W-1:0] {
      SRC_SLOW = 2'd0,
      SRC_OSC  = 2'd1,
      SRC_PLL  = 2'd2,
      SRC_KEEP = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_DROP,
      ST_GAP,
      ST_RAISE
   } sw_st_e;
endpackage

// File: rtl/mck_sync.sv
module mck_sync #(
   parameter int   STAGES = 2,
   parameter int   W      = 1,
   parameter logic INIT   = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mck_sync: STAGES must be at least 2");
   end

   logic [W-1:0] sh [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) sh[i] <= {W{INIT}};
      end else begin
         sh[0] <= d;
         for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
      end
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/mck_gate.sv
module mck_gate #(
   parameter int SYNC_STAGES = 2,
   parameter int ON_CYCLES   = 3,
   parameter bit INIT_ON     = 1'b0
) (
   input  logic clk_src,
   input  logic clk_ctl,
   input  logic rst_n,
   input  logic en_req,
   output logic clk_gated,
   output logic gate_on,
   output logic ack
);
   localparam int CNT_W = $clog2(ON_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(ON_CYCLES);
   localparam logic [CNT_W-1:0] CNT_INIT = INIT_ON ? CNT_TOP : '0;

   if (ON_CYCLES < 1) begin : g_bad_on
      $error("mck_gate: ON_CYCLES must be at least 1");
   end

   logic             en_s;
   logic [CNT_W-1:0] cnt;
   logic             arm_q;
   logic             gate_q;

   // request from the control domain into this source's domain
   mck_sync #(.STAGES(SYNC_STAGES), .W(1), .INIT(INIT_ON)) u_req_sync (
      .clk   (clk_src),
      .rst_n (rst_n),
      .d     (en_req),
      .q     (en_s)
   );

   // count settle cycles of this clock before arming the gate
   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= CNT_INIT;
         arm_q <= INIT_ON;
      end else if (!en_s) begin
         cnt   <= '0;
         arm_q <= 1'b0;
      end else begin
         if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
         arm_q <= (cnt == CNT_TOP);
      end
   end

   // gate changes only while the source clock is low
   always_ff @(negedge clk_src or negedge rst_n) begin
      if (!rst_n) gate_q <= INIT_ON;
      else        gate_q <= arm_q;
   end

   assign clk_gated = clk_src & gate_q;
   assign gate_on   = gate_q;

   // gate state back into the control domain
   mck_sync #(.STAGES(SYNC_STAGES), .W(1), .INIT(INIT_ON)) u_ack_sync (
      .clk   (clk_ctl),
      .rst_n (rst_n),
      .d     (gate_q),
      .q     (ack)
   );

   AST_GATE_NEEDS_ARM: assert property (@(negedge clk_src) disable iff (!rst_n)
      (gate_q && !$past(gate_q)) |-> $past(arm_q)) else $error("gate opened without arm"); // R2
endmodule

// File: rtl/mck_prescaler.sv
module mck_prescaler #(
   parameter int DIV_MAX     = 6,
   parameter int SYNC_STAGES = 2,
   parameter int CODE_W      = 3
) (
   input  logic              clk_in,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] div_code,
   output logic              clk_out
);
   if (DIV_MAX > (1 << CODE_W) - 2) begin : g_bad_max
      $error("mck_prescaler: DIV_MAX leaves no reserved keep code");
   end

   if (DIV_MAX == 0) begin : g_bypass
      assign clk_out = clk_in;
   end else begin : g_div
      localparam int CW = DIV_MAX;

      logic [CODE_W-1:0] code_s;
      logic [CODE_W-1:0] code_d;
      logic [CODE_W-1:0] cur_n;
      logic [CW-1:0]     cnt;
      logic              out_q;
      logic [CW:0]       last_w;
      logic [CW:0]       half_w;
      logic [CW:0]       nxt_w;
      logic              wrap;
      logic              steady;

      mck_sync #(.STAGES(SYNC_STAGES), .W(CODE_W), .INIT(1'b0)) u_code_sync (
         .clk   (clk_in),
         .rst_n (rst_n),
         .d     (div_code),
         .q     (code_s)
      );

      always_comb begin
         last_w = ((CW+1)'(1) << cur_n) - (CW+1)'(1);
         half_w = ((CW+1)'(1) << cur_n) >> 1;
         nxt_w  = {1'b0, cnt} + (CW+1)'(1);
         wrap   = ({1'b0, cnt} == last_w);
         steady = (code_s == code_d);
      end

      always_ff @(posedge clk_in or negedge rst_n) begin
         if (!rst_n) begin
            code_d <= '0;
            cur_n  <= '0;
            cnt    <= '0;
            out_q  <= 1'b1;
         end else begin
            code_d <= code_s;
            if (wrap) begin
               cnt   <= '0;
               out_q <= 1'b1;
               if (steady) cur_n <= code_s;
            end else begin
               cnt   <= nxt_w[CW-1:0];
               out_q <= (nxt_w < half_w);
            end
         end
      end

      assign clk_out = (cur_n == '0) ? clk_in : out_q;

      AST_DIV_BOUNDARY: assert property (@(posedge clk_in) disable iff (!rst_n)
         (cur_n != $past(cur_n)) |-> (cnt == '0)) else $error("ratio changed mid-period"); // R8
      AST_DIV_RANGE: assert property (@(posedge clk_in) disable iff (!rst_n)
         cur_n <= CODE_W'(DIV_MAX)) else $error("ratio out of range"); // R7
   end
endmodule

// File: rtl/mck_ctrl.sv
module mck_ctrl
   import mck_pkg::*;
#(
   parameter int GAP_CYCLES = 3,
   parameter int DIV_MAX    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [SRC_W-1:0] cfg_src,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_pad_off,
   input  logic             cfg_irq_mask,
   input  logic             cfg_flag_clr,
   input  logic [NSRC-1:0]  ack,
   output logic [NSRC-1:0]  en_req,
   output logic             busy,
   output logic [SRC_W-1:0] src_now,
   output logic [DIV_W-1:0] div_code,
   output logic             pad_off,
   output logic             slow_flag,
   output logic             irq
);
   localparam int GAP_W = $clog2(GAP_CYCLES + 1);

   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("mck_ctrl: GAP_CYCLES must be at least 1");
   end

   sw_st_e           st;
   logic [SRC_W-1:0] cur_q;
   logic [SRC_W-1:0] tgt_q;
   logic [GAP_W-1:0] gap_cnt;
   logic             mask_q;
   logic             accept;
   logic             src_ok;

   assign accept = cfg_wr && (st == ST_IDLE);
   assign src_ok = (cfg_src != SRC_KEEP) && (cfg_src != cur_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cur_q     <= SRC_SLOW;
         tgt_q     <= SRC_SLOW;
         en_req    <= NSRC'(1);
         gap_cnt   <= '0;
         div_code  <= '0;
         pad_off   <= 1'b0;
         mask_q    <= 1'b0;
         slow_flag <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  if (cfg_div <= DIV_W'(DIV_MAX)) div_code <= cfg_div;
                  pad_off <= cfg_pad_off;
                  mask_q  <= cfg_irq_mask;
                  if (cfg_flag_clr) slow_flag <= 1'b0;
                  if (src_ok) begin
                     tgt_q         <= cfg_src;
                     en_req[cur_q] <= 1'b0;
                     st            <= ST_DROP;
                  end
               end
            end
            ST_DROP: begin
               if (ack == '0) begin
                  gap_cnt <= GAP_W'(GAP_CYCLES);
                  st      <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (gap_cnt == '0) begin
                  en_req[tgt_q] <= 1'b1;
                  st            <= ST_RAISE;
               end else begin
                  gap_cnt <= gap_cnt - 1'b1;
               end
            end
            ST_RAISE: begin
               if (ack[tgt_q]) begin
                  cur_q <= tgt_q;
                  st    <= ST_IDLE;
                  if (tgt_q == SRC_SLOW) slow_flag <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st != ST_IDLE);
   assign src_now = cur_q;
   assign irq     = slow_flag & mask_q;

   AST_IDLE_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (ack == (NSRC'(1) << cur_q))) else $error("idle with wrong gate"); // R1
   AST_GAP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_GAP) |-> (ack == '0)) else $error("gate open during gap"); // R2
   AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_wr) |=> ($stable(div_code) && $stable(mask_q) && $stable(pad_off))) else $error("write taken while busy"); // R4
   AST_FLAG_ON_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slow_flag) |-> (cur_q == SRC_SLOW)) else $error("flag set off slow clock"); // R9
endmodule

// File: rtl/mck_switch.sv
module mck_switch
   import mck_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ON_CYCLES   = 3,
   parameter int GAP_CYCLES  = 3,
   parameter int DIV_MAX     = 6
) (
   input  logic       clk_slow,
   input  logic       clk_osc,
   input  logic       clk_pll,
   input  logic       rst_n,
   input  logic       cfg_wr,
   input  logic [1:0] cfg_src,
   input  logic [2:0] cfg_div,
   input  logic       cfg_pad_off,
   input  logic       cfg_irq_mask,
   input  logic       cfg_flag_clr,
   output logic       busy,
   output logic [1:0] src_now,
   output logic       slow_flag,
   output logic       irq,
   output logic       mck,
   output logic       mck_pad
);
   logic [NSRC-1:0]  clk_vec;
   logic [NSRC-1:0]  clk_g;
   logic [NSRC-1:0]  gate_on;
   logic [NSRC-1:0]  ack;
   logic [NSRC-1:0]  en_req;
   logic [DIV_W-1:0] div_code;
   logic             pad_off;
   logic             mck_raw;

   assign clk_vec = {clk_pll, clk_osc, clk_slow};

   mck_ctrl #(.GAP_CYCLES(GAP_CYCLES), .DIV_MAX(DIV_MAX)) u_ctrl (
      .clk          (clk_slow),
      .rst_n        (rst_n),
      .cfg_wr       (cfg_wr),
      .cfg_src      (cfg_src),
      .cfg_div      (cfg_div),
      .cfg_pad_off  (cfg_pad_off),
      .cfg_irq_mask (cfg_irq_mask),
      .cfg_flag_clr (cfg_flag_clr),
      .ack          (ack),
      .en_req       (en_req),
      .busy         (busy),
      .src_now      (src_now),
      .div_code     (div_code),
      .pad_off      (pad_off),
      .slow_flag    (slow_flag),
      .irq          (irq)
   );

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      mck_gate #(
         .SYNC_STAGES (SYNC_STAGES),
         .ON_CYCLES   (ON_CYCLES),
         .INIT_ON     (g == 0)
      ) u_gate (
         .clk_src   (clk_vec[g]),
         .clk_ctl   (clk_slow),
         .rst_n     (rst_n),
         .en_req    (en_req[g]),
         .clk_gated (clk_g[g]),
         .gate_on   (gate_on[g]),
         .ack       (ack[g])
      );
   end

   assign mck_raw = |clk_g;

   mck_prescaler #(.DIV_MAX(DIV_MAX), .SYNC_STAGES(SYNC_STAGES), .CODE_W(DIV_W)) u_div (
      .clk_in   (mck_raw),
      .rst_n    (rst_n),
      .div_code (div_code),
      .clk_out  (mck)
   );

   assign mck_pad = pad_off ? 1'bz : mck;

   AST_ONE_GATE: assert property (@(posedge clk_slow) disable iff (!rst_n)
      $onehot0(gate_on)) else $error("two gates open"); // R2
endmodule

// File: tb/test_mck_switch.sv
`timescale 1ns/1ps
module test_mck_switch;
   localparam real CLK_PERIOD = 40.0;
   localparam real OSC_PERIOD = 14.0;
   localparam real PLL_PERIOD = 6.0;

   logic       clk_slow = 1'b0;
   logic       clk_osc  = 1'b0;
   logic       clk_pll  = 1'b0;
   logic       rst_n    = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [1:0] cfg_src = 2'd3;
   logic [2:0] cfg_div = 3'd7;
   logic       cfg_pad_off = 1'b0;
   logic       cfg_irq_mask = 1'b0;
   logic       cfg_flag_clr = 1'b0;
   logic       busy, slow_flag, irq, mck;
   wire        mck_pad;
   logic [1:0] src_now;

   int n_chk = 0;
   int n_fail = 0;
   int glitches = 0;
   int exp_src = 0;
   int exp_div = 0;
   bit exp_mask = 1'b0;

   always #(CLK_PERIOD/2) clk_slow = ~clk_slow;
   always #(OSC_PERIOD/2) clk_osc  = ~clk_osc;
   always #(PLL_PERIOD/2) clk_pll  = ~clk_pll;

   mck_switch i_mck_switch (
      .clk_slow, .clk_osc, .clk_pll, .rst_n,
      .cfg_wr, .cfg_src, .cfg_div, .cfg_pad_off, .cfg_irq_mask, .cfg_flag_clr,
      .busy, .src_now, .slow_flag, .irq, .mck, .mck_pad
   );

   // runt-pulse monitor on the pad (R2)
   real  last_t = 0.0;
   logic last_v = 1'bz;
   always @(mck_pad) begin
      if (rst_n && mck_pad !== 1'bz && last_v !== 1'bz && ($realtime - last_t) < 2.9)
         glitches++;
      last_t = $realtime;
      last_v = mck_pad;
   end

   function automatic real src_per(int s);
      if (s == 1) return OSC_PERIOD;
      if (s == 2) return PLL_PERIOD;
      return CLK_PERIOD;
   endfunction

   task automatic check(input bit ok, input string req, input string what, input real act, input real exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] s, input logic [2:0] d, input bit pad, input bit msk, input bit clr);
      @(negedge clk_slow);
      cfg_wr = 1'b1; cfg_src = s; cfg_div = d;
      cfg_pad_off = pad; cfg_irq_mask = msk; cfg_flag_clr = clr;
      @(negedge clk_slow);
      cfg_wr = 1'b0; cfg_flag_clr = 1'b0;
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (busy) begin
         @(negedge clk_slow);
         cyc++;
      end
   endtask

   task automatic measure(output real per, output real hi);
      real t0, t1, t2;
      repeat (4) @(posedge mck_pad);
      t0 = $realtime;
      @(negedge mck_pad); t1 = $realtime;
      @(posedge mck_pad); t2 = $realtime;
      per = t2 - t0;
      hi  = t1 - t0;
   endtask

   task automatic check_clock(input string req);
      real per, hi, ep;
      measure(per, hi);
      ep = src_per(exp_src) * real'(1 << exp_div);
      check((per > ep - 0.5) && (per < ep + 0.5), req, "period", per, ep);
      check((hi > ep/2 - 0.5) && (hi < ep/2 + 0.5), req, "high time", hi, ep/2);
   endtask

   task automatic do_switch(input int s, input int d, input string req);
      int cyc;
      bit go_slow;
      go_slow = (s == 0) && (exp_src != 0);
      cfg_write(2'(s), 3'(d), 1'b0, exp_mask, 1'b0);
      check(busy == 1'b1, "R3", "busy after write", real'(busy), 1.0);
      wait_idle(cyc);
      check(cyc >= 5 && cyc <= 40, "R3", "busy cycles", real'(cyc), 10.0);
      exp_src = s;
      if (d != 7) exp_div = d;
      check(int'(src_now) == exp_src, req, "src_now", real'(src_now), real'(exp_src));
      if (go_slow) check(slow_flag == 1'b1, "R9", "flag after slow switch", real'(slow_flag), 1.0);
      check_clock(req);
   endtask

   initial begin
      void'($urandom(32'd1234));
      #(CLK_PERIOD * 2.5);
      rst_n = 1'b1;
      @(negedge clk_slow);
      // reset state
      check(busy == 1'b0, "R3", "busy at reset", real'(busy), 0.0);
      check(src_now == 2'd0, "R1", "reset source", real'(src_now), 0.0);
      check(slow_flag == 1'b0 && irq == 1'b0, "R10", "flag/irq at reset", real'(irq), 0.0);
      check(mck_pad !== 1'bz, "R11", "pad enabled at reset", 0.0, 0.0);
      check_clock("R7");

      // slow -> oscillator, then a write during the switch to PLL
      do_switch(1, 0, "R1");
      cfg_write(2'd2, 3'd7, 1'b0, 1'b0, 1'b0);
      cfg_write(2'd0, 3'd3, 1'b1, 1'b1, 1'b0);   // ignored (R4)
      begin
         int cyc;
         wait_idle(cyc);
      end
      exp_src = 2;
      check(src_now == 2'd2, "R4", "source after busy write", real'(src_now), 2.0);
      check(mck_pad !== 1'bz, "R4", "pad bit kept", 0.0, 0.0);
      check(irq == 1'b0 && slow_flag == 1'b0, "R4", "no slow switch", real'(slow_flag), 0.0);
      check_clock("R4");

      // ratio change on the same source, no switch
      cfg_write(2'd2, 3'd3, 1'b0, 1'b0, 1'b0);
      check(busy == 1'b0, "R5", "same source no busy", real'(busy), 0.0);
      exp_div = 3;
      check_clock("R6");
      // keep code 7 and keep source code 11
      cfg_write(2'd3, 3'd7, 1'b0, 1'b0, 1'b0);
      check(busy == 1'b0, "R5", "code 11 no busy", real'(busy), 0.0);
      check(src_now == 2'd2, "R5", "code 11 source", real'(src_now), 2.0);
      check_clock("R7");
      cfg_write(2'd3, 3'd0, 1'b0, 1'b0, 1'b0);
      exp_div = 0;
      check_clock("R8");

      // pad disable
      cfg_write(2'd3, 3'd7, 1'b1, 1'b0, 1'b0);
      begin
         bit allz = 1'b1;
         for (int i = 0; i < 20; i++) begin
            #(PLL_PERIOD * 0.37);
            if (mck_pad !== 1'bz) allz = 1'b0;
         end
         check(allz, "R11", "pad tri-stated", 0.0, 0.0);
      end
      cfg_write(2'd3, 3'd7, 1'b0, 1'b0, 1'b0);
      check(mck_pad !== 1'bz, "R11", "pad re-enabled", 0.0, 0.0);

      // to slow with mask off, then mask on, then clear
      do_switch(0, 2, "R1");
      check(irq == 1'b0, "R10", "masked irq", real'(irq), 0.0);
      exp_mask = 1'b1;
      cfg_write(2'd3, 3'd7, 1'b0, 1'b1, 1'b0);
      check(irq == 1'b1, "R10", "unmasked irq", real'(irq), 1.0);
      check(slow_flag == 1'b1, "R9", "flag sticky", real'(slow_flag), 1.0);
      cfg_write(2'd3, 3'd7, 1'b0, 1'b1, 1'b1);
      check(slow_flag == 1'b0 && irq == 1'b0, "R9", "flag cleared", real'(slow_flag), 0.0);

      // seeded random sources and ratios
      for (int k = 0; k < 10; k++) begin
         int s, d;
         s = int'($urandom % 3);
         d = int'($urandom % 7);
         if (s != exp_src) begin
            do_switch(s, d, "R6");
         end else begin
            cfg_write(2'(s), 3'(d), 1'b0, exp_mask, 1'b0);
            exp_div = d;
            check(busy == 1'b0, "R5", "random same source", real'(busy), 0.0);
            check_clock("R6");
         end
         cfg_write(2'd3, 3'd7, 1'b0, exp_mask, 1'b1);
      end

      check(glitches == 0, "R2", "runt phases", real'(glitches), 0.0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule